// File: doc/BRIEF.md
# 8-bit Accumulator ALU with Program Status Flags

This block is the arithmetic core of a small 8-bit processor. It holds three registers: an accumulator, a B register and a program status word. When the opcode strobe is high, it runs one of five operations and updates the carry, half-carry and signed-overflow flags by the rules that belong to that operation. The five operations are add, add with carry, subtract with borrow, multiply and divide. The accumulator, B and the status word can also be written directly, and are read back on dedicated ports.

The status word also holds two flags that software owns and a two-bit bank field. The bank field moves an 8-byte register window through the lowest 32 bytes of internal RAM. A 3-bit register index is turned into the matching 5-bit RAM address without any clock delay. The parity bit is not stored: it is derived at every instant from the current accumulator contents.

All register updates land on the clock edge that samples the strobe, so results appear on the outputs one cycle after the request.

Top module: `alu8_core`

## Requirements
- R1: A synchronous reset clears the accumulator, B and the whole status word to 0x00.
- R2: op_code 1 (add) loads acc+op_arg into the accumulator. Status bit 7 (CY) is set on a carry out of bit 7. Bit 6 (AC) is set on a carry out of bit 3. Bit 2 (OV) is set when two operands of equal sign give a result of the other sign.
- R3: op_code 2 (add with carry) adds the current CY as well, and derives CY, AC and OV from the whole sum including that carry-in.
- R4: op_code 3 (subtract with borrow) loads acc-op_arg-CY. CY is set on a borrow into bit 7 and AC on a borrow from the upper nibble. OV is set when operands of differing sign give a result whose sign differs from the accumulator's.
- R5: op_code 4 (multiply) puts the low byte of acc*B in the accumulator and the high byte in B. It sets OV exactly when the product exceeds 255, and clears CY and AC.
- R6: op_code 5 (divide) with B nonzero puts the quotient in the accumulator and the remainder in B, and clears CY, AC and OV.
- R7: Divide with B equal to zero leaves the accumulator and B unchanged, sets OV and clears CY and AC. A direct accumulator or B write in that cycle is dropped.
- R8: Status bit 0 is 1 when the accumulator holds an odd number of one bits and 0 otherwise, at every instant. The value written to bit 0 is ignored.
- R9: The status word layout from bit 7 down is CY, AC, F0, bank[1], bank[0], OV, F1, parity. A direct write loads bits 7..1 on the next clock.
- R10: When an operation and direct writes land in the same cycle, the operation sets the registers it produces (ACC, and B for multiply and divide) and CY, AC and OV. Status bits F0, bank and F1 take the written value.
- R11: reg_addr equals {bank[1:0], reg_idx}, formed combinationally from the current status word.
- R12: With op_valid low, or with op_code 0, 6 or 7, no arithmetic takes place. The registers change only through direct writes.
- R13: acc_wr and b_wr load the accumulator and B on the next clock when no operation overrides them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | Operation strobe |
| op_code | input | 3 | Operation select (1 add, 2 add with carry, 3 subtract with borrow, 4 multiply, 5 divide) |
| op_arg | input | 8 | Second operand for add and subtract |
| b_wr | input | 1 | Direct write enable for B |
| b_wdata | input | 8 | Direct write data for B |
| b_q | output | 8 | Current B register |
| acc_wr | input | 1 | Direct write enable for the accumulator |
| acc_wdata | input | 8 | Direct write data for the accumulator |
| acc_q | output | 8 | Current accumulator |
| psw_wr | input | 1 | Direct write enable for the status word |
| psw_wdata | input | 8 | Direct write data for the status word (bit 0 ignored) |
| psw_q | output | 8 | Current status word with live parity |
| reg_idx | input | 3 | Register index within the bank |
| reg_addr | output | 5 | Bank-relative RAM address |

## Verification
The assertions check several behaviours on every cycle. They confirm that multiply returns the exact 16-bit product across both registers and clears CY and AC. They confirm that a zero-divisor divide holds both registers and raises OV, and that a plain status write lands on bits 7..1. They confirm that a written parity bit never overrides the computed one and that the registers are clear after reset. The add and subtract flag rules, the carry-in for add with carry and subtract with borrow, and the split priority when an operation meets a status write are shown only by the bench's directed scenarios. The same holds for the divide quotient and remainder and the bank address mapping. In those scenarios, a reference model predicts every register after each step.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    localparam int DW     = 8;
    localparam int IDX_W  = 3;
    localparam int BANK_W = 2;
    localparam int ADDR_W = IDX_W + BANK_W;

    typedef enum logic [2:0] {
        OP_NONE = 3'd0,
        OP_ADD  = 3'd1,
        OP_ADDC = 3'd2,
        OP_SUBB = 3'd3,
        OP_MUL  = 3'd4,
        OP_DIV  = 3'd5
    } alu_op_e;

    // Stored status bits; parity is derived, never stored.
    typedef struct packed {
        logic              cy;
        logic              ac;
        logic              f0;
        logic [BANK_W-1:0] rs;
        logic              ov;
        logic              f1;
    } flags_t;

    typedef struct packed {
        logic [DW-1:0] acc;
        logic [DW-1:0] b;
        flags_t        fl;
    } regs_t;

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    input  logic         sub,
    output logic [W-1:0] res,
    output logic         cy,
    output logic         ac,
    output logic         ov
);
    localparam int HALF = W / 2;

    logic [W:0]    full_w;
    logic [HALF:0] low_w;

    always_comb begin
        if (sub) begin
            full_w = {1'b0, a} - {1'b0, b} - (W+1)'(cin);
            low_w  = {1'b0, a[HALF-1:0]} - {1'b0, b[HALF-1:0]} - (HALF+1)'(cin);
        end else begin
            full_w = {1'b0, a} + {1'b0, b} + (W+1)'(cin);
            low_w  = {1'b0, a[HALF-1:0]} + {1'b0, b[HALF-1:0]} + (HALF+1)'(cin);
        end
        res = full_w[W-1:0];
        cy  = full_w[W];
        ac  = low_w[HALF];
        if (sub)
            ov = (a[W-1] != b[W-1]) && (res[W-1] != a[W-1]);
        else
            ov = (a[W-1] == b[W-1]) && (res[W-1] != a[W-1]);
    end
endmodule

// File: rtl/alu8_muldiv.sv
module alu8_muldiv #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         div,
    output logic [W-1:0] lo,
    output logic [W-1:0] hi,
    output logic         ov
);
    logic [2*W-1:0] prod_w;

    assign prod_w = {{W{1'b0}}, a} * {{W{1'b0}}, b};

    always_comb begin
        if (!div) begin
            lo = prod_w[W-1:0];
            hi = prod_w[2*W-1:W];
            ov = |prod_w[2*W-1:W];
        end else if (b == '0) begin
            lo = a;
            hi = b;
            ov = 1'b1;
        end else begin
            lo = a / b;
            hi = a % b;
            ov = 1'b0;
        end
    end
endmodule

// File: rtl/alu8_bankmap.sv
module alu8_bankmap #(
    parameter int IDX_W  = 3,
    parameter int BANK_W = 2
) (
    input  logic [BANK_W-1:0]       bank,
    input  logic [IDX_W-1:0]        idx,
    output logic [BANK_W+IDX_W-1:0] addr
);
    assign addr = {bank, idx};
endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              op_valid,
    input  logic [2:0]        op_code,
    input  logic [DW-1:0]     op_arg,
    input  logic              b_wr,
    input  logic [DW-1:0]     b_wdata,
    output logic [DW-1:0]     b_q,
    input  logic              acc_wr,
    input  logic [DW-1:0]     acc_wdata,
    output logic [DW-1:0]     acc_q,
    input  logic              psw_wr,
    input  logic [DW-1:0]     psw_wdata,
    output logic [DW-1:0]     psw_q,
    input  logic [IDX_W-1:0]  reg_idx,
    output logic [ADDR_W-1:0] reg_addr
);
    regs_t st_d, st_q;

    logic          is_arith, is_md, use_cin;
    logic [DW-1:0] as_res, md_lo, md_hi;
    logic          as_cy, as_ac, as_ov, md_ov;

    assign is_arith = op_valid && (op_code == OP_ADD || op_code == OP_ADDC
                                   || op_code == OP_SUBB);
    assign is_md    = op_valid && (op_code == OP_MUL || op_code == OP_DIV);
    assign use_cin  = (op_code == OP_ADDC || op_code == OP_SUBB) && st_q.fl.cy;

    alu8_addsub #(.W(DW)) u_addsub (
        .a   (st_q.acc),
        .b   (op_arg),
        .cin (use_cin),
        .sub (op_code == OP_SUBB),
        .res (as_res),
        .cy  (as_cy),
        .ac  (as_ac),
        .ov  (as_ov)
    );

    alu8_muldiv #(.W(DW)) u_muldiv (
        .a   (st_q.acc),
        .b   (st_q.b),
        .div (op_code == OP_DIV),
        .lo  (md_lo),
        .hi  (md_hi),
        .ov  (md_ov)
    );

    alu8_bankmap #(.IDX_W(IDX_W), .BANK_W(BANK_W)) u_bankmap (
        .bank (st_q.fl.rs),
        .idx  (reg_idx),
        .addr (reg_addr)
    );

    always_comb begin
        st_d = st_q;
        if (acc_wr) st_d.acc = acc_wdata;
        if (b_wr)   st_d.b   = b_wdata;
        if (psw_wr) st_d.fl  = flags_t'(psw_wdata[DW-1:1]);
        if (is_arith) begin
            st_d.acc   = as_res;
            st_d.fl.cy = as_cy;
            st_d.fl.ac = as_ac;
            st_d.fl.ov = as_ov;
        end else if (is_md) begin
            st_d.acc   = md_lo;
            st_d.b     = md_hi;
            st_d.fl.cy = 1'b0;
            st_d.fl.ac = 1'b0;
            st_d.fl.ov = md_ov;
        end
        if (rst) st_d = '0;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign acc_q = st_q.acc;
    assign b_q   = st_q.b;
    assign psw_q = {st_q.fl, ^st_q.acc};

    // R1: registers are clear in the first cycle out of reset
    a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (acc_q == '0 && b_q == '0 && psw_q == '0));

    // R5: multiply leaves the full product across B:ACC
    a_r5_mul_product: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == OP_MUL) |=>
        ({b_q, acc_q} == (16'($past(acc_q)) * 16'($past(b_q)))));

    // R5: multiply clears CY and AC
    a_r5_mul_flags: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == OP_MUL) |=> (!psw_q[7] && !psw_q[6]));

    // R7: zero divisor holds both registers and raises OV
    a_r7_div0_hold: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == OP_DIV && b_q == '0) |=>
        (psw_q[2] && acc_q == $past(acc_q) && b_q == $past(b_q)));

    // R9: a plain status write lands on bits 7..1
    a_r9_psw_write: assert property (@(posedge clk) disable iff (rst)
        (psw_wr && !op_valid) |=> (psw_q[7:1] == $past(psw_wdata[7:1])));

    // R8: a written parity bit never overrides the computed one
    a_r8_parity_ignored: assert property (@(posedge clk) disable iff (rst)
        (psw_wr && !op_valid && !acc_wr && (psw_wdata[0] != ^acc_q)) |=>
        (psw_q[0] == $past(^acc_q)));

endmodule

// File: tb/tb_alu8_core.sv
`timescale 1ns/1ps
module tb_alu8_core;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       op_valid = 1'b0;
    logic [2:0] op_code = '0;
    logic [7:0] op_arg = '0;
    logic       b_wr = 1'b0, acc_wr = 1'b0, psw_wr = 1'b0;
    logic [7:0] b_wdata = '0, acc_wdata = '0, psw_wdata = '0;
    logic [7:0] b_q, acc_q, psw_q;
    logic [2:0] reg_idx = '0;
    logic [4:0] reg_addr;

    always #2.5 clk = ~clk;

    alu8_core dut (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
        .op_arg(op_arg), .b_wr(b_wr), .b_wdata(b_wdata), .b_q(b_q),
        .acc_wr(acc_wr), .acc_wdata(acc_wdata), .acc_q(acc_q),
        .psw_wr(psw_wr), .psw_wdata(psw_wdata), .psw_q(psw_q),
        .reg_idx(reg_idx), .reg_addr(reg_addr)
    );

    typedef struct {
        string      req;
        logic [7:0] acc;
        logic [7:0] b;
        logic [7:0] psw;
    } exp_t;

    exp_t exp_q[$];
    int   total = 0, bad = 0;
    bit   done = 1'b0;

    int m_acc = 0, m_b = 0, m_cy = 0, m_ac = 0, m_f0 = 0, m_rs = 0, m_ov = 0, m_f1 = 0;

    function automatic int sgn(input int v);
        return (v > 127) ? v - 256 : v;
    endfunction

    function automatic logic [7:0] model_psw();
        logic [7:0] p;
        p = {1'(m_cy), 1'(m_ac), 1'(m_f0), 2'(m_rs), 1'(m_ov), 1'(m_f1),
             1'($countones(8'(m_acc)) % 2)};
        return p;
    endfunction

    task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp_v,
                          input string what);
        total++;
        if (act !== exp_v) begin
            bad++;
            $display("FAIL %s %s actual=%02h expected=%02h", req, what, act, exp_v);
        end
    endtask

    // Driver: applies one cycle of stimulus, predicts the result, queues it.
    task automatic drive(input string req, input bit v, input int code, input int arg,
                         input bit aw, input int ad, input bit bw, input int bd,
                         input bit pw, input int pd, input int idx);
        int n_acc, n_b, s, sr;
        exp_t e;
        @(negedge clk);
        op_valid = v; op_code = 3'(code); op_arg = 8'(arg);
        acc_wr = aw; acc_wdata = 8'(ad); b_wr = bw; b_wdata = 8'(bd);
        psw_wr = pw; psw_wdata = 8'(pd); reg_idx = 3'(idx);
        #1;
        // R11: combinational bank address from the current bank field
        check8("R11", {3'b000, reg_addr}, 8'((m_rs << 3) | idx), "reg_addr");
        n_acc = aw ? ad : m_acc;
        n_b   = bw ? bd : m_b;
        if (pw) begin
            m_f0 = (pd >> 5) & 1; m_rs = (pd >> 3) & 3; m_f1 = (pd >> 1) & 1;
            m_cy = (pd >> 7) & 1; m_ac = (pd >> 6) & 1; m_ov = (pd >> 2) & 1;
        end
        if (v) begin
            case (code)
                1, 2: begin
                    int c;
                    c = (code == 2) ? ((pw ? 0 : 0) + cur_cy) : 0;
                    s = m_acc + arg + c;
                    n_acc = s % 256;
                    m_cy = (s > 255);
                    m_ac = ((m_acc % 16) + (arg % 16) + c) > 15;
                    sr = sgn(m_acc) + sgn(arg) + c;
                    m_ov = (sr > 127 || sr < -128);
                end
                3: begin
                    int c;
                    c = cur_cy;
                    s = m_acc - arg - c;
                    n_acc = (s + 256) % 256;
                    m_cy = (s < 0);
                    m_ac = ((m_acc % 16) - (arg % 16) - c) < 0;
                    sr = sgn(m_acc) - sgn(arg) - c;
                    m_ov = (sr > 127 || sr < -128);
                end
                4: begin
                    s = m_acc * m_b;
                    n_acc = s % 256; n_b = s / 256;
                    m_cy = 0; m_ac = 0; m_ov = (s > 255);
                end
                5: begin
                    m_cy = 0; m_ac = 0;
                    if (m_b == 0) begin
                        n_acc = m_acc; n_b = m_b; m_ov = 1;
                    end else begin
                        n_acc = m_acc / m_b; n_b = m_acc % m_b; m_ov = 0;
                    end
                end
                default: ;
            endcase
        end
        m_acc = n_acc; m_b = n_b;
        e.req = req; e.acc = 8'(m_acc); e.b = 8'(m_b); e.psw = model_psw();
        exp_q.push_back(e);
    endtask

    // CY as held before the current cycle's writes (sampled before the task edits it)
    int cur_cy = 0;

    task automatic op(input string req, input int code, input int arg);
        cur_cy = m_cy;
        drive(req, 1'b1, code, arg, 1'b0, 0, 1'b0, 0, 1'b0, 0, 0);
    endtask
    task automatic wacc(input string req, input int v);
        drive(req, 1'b0, 0, 0, 1'b1, v, 1'b0, 0, 1'b0, 0, 0);
    endtask
    task automatic wb(input string req, input int v);
        drive(req, 1'b0, 0, 0, 1'b0, 0, 1'b1, v, 1'b0, 0, 0);
    endtask
    task automatic wpsw(input string req, input int v, input int idx);
        drive(req, 1'b0, 0, 0, 1'b0, 0, 1'b0, 0, 1'b1, v, idx);
    endtask

    // Monitor: compares each queued prediction after the edge that produces it
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                check8(e.req, acc_q, e.acc, "acc");
                check8(e.req, b_q, e.b, "b");
                check8(e.req, psw_q, e.psw, "psw");
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: reset state
        check8("R1", acc_q, 8'h00, "acc");
        check8("R1", b_q, 8'h00, "b");
        check8("R1", psw_q, 8'h00, "psw");

        wacc("R13", 8'h7F);
        wb("R13", 8'h03);
        op("R2", 1, 8'h01);
        wacc("R13", 8'hFF);
        op("R2", 1, 8'h01);
        op("R3", 2, 8'h10);
        op("R3", 2, 8'h7F);
        wpsw("R9", 8'h00, 0);
        wacc("R13", 8'h00);
        op("R4", 3, 8'h01);
        op("R4", 3, 8'h00);
        wpsw("R9", 8'h00, 1);
        wacc("R13", 8'h80);
        op("R4", 3, 8'h01);
        op("R4", 3, 8'h00);
        wacc("R13", 8'h10);
        wb("R13", 8'h20);
        op("R5", 4, 0);
        wacc("R13", 8'h03);
        wb("R13", 8'h05);
        op("R5", 4, 0);
        wacc("R13", 100);
        wb("R13", 7);
        op("R6", 5, 0);
        wb("R13", 0);
        op("R7", 5, 0);
        // R7: zero divide drops a same-cycle direct write
        cur_cy = m_cy;
        drive("R7", 1'b1, 5, 0, 1'b1, 8'h55, 1'b1, 8'h66, 1'b0, 0, 0);
        // R8: written parity ignored for both even and odd accumulators
        wacc("R8", 8'h06);
        wpsw("R8", 8'h01, 2);
        wacc("R8", 8'h07);
        wpsw("R8", 8'h00, 3);
        // R9: layout of stored bits
        wpsw("R9", 8'hA6, 4);
        wpsw("R9", 8'h5A, 5);
        // R10: operation and status/accumulator writes in one cycle
        wacc("R10", 8'h7F);
        cur_cy = m_cy;
        drive("R10", 1'b1, 1, 8'h01, 1'b1, 8'h11, 1'b0, 0, 1'b1, 8'h00, 6);
        cur_cy = m_cy;
        drive("R10", 1'b1, 3, 8'h01, 1'b0, 0, 1'b0, 0, 1'b1, 8'hFF, 7);
        // R11: every bank with a spread of indexes
        for (int k = 0; k < 4; k++) begin
            wpsw("R11", k << 3, 7 - k);
            wpsw("R11", k << 3, k * 2);
        end
        // R12: unused codes and a dropped strobe change nothing
        drive("R12", 1'b1, 6, 8'h22, 1'b0, 0, 1'b0, 0, 1'b0, 0, 0);
        drive("R12", 1'b1, 7, 8'h22, 1'b0, 0, 1'b0, 0, 1'b0, 0, 0);
        drive("R12", 1'b1, 0, 8'h22, 1'b0, 0, 1'b0, 0, 1'b0, 0, 0);
        drive("R12", 1'b0, 1, 8'h22, 1'b0, 0, 1'b0, 0, 1'b0, 0, 0);
        drive("R12", 1'b0, 4, 0, 1'b0, 0, 1'b0, 0, 1'b0, 0, 0);

        @(negedge clk);
        op_valid = 1'b0; acc_wr = 1'b0; b_wr = 1'b0; psw_wr = 1'b0;
        while (exp_q.size() > 0) @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule